// File: doc/BRIEF.md
# Architectural Register Copy File

This block keeps a second, small copy of integer register values whose producers finished long ago. It lets a single-issue in-order side lane read its operands without going through the physical register file. It has one entry per architectural register. Each entry carries a valid flag that says whether the stored copy is current. Steering logic and the side lane read the block through two combinational read ports. Each port returns the stored value and its valid flag for the register number presented.

Results arrive on several write-back lanes. The lower-numbered lanes come from the out-of-order core, and the highest-numbered lane comes from the side lane. A result is copied only when its physical destination still holds the newest renaming of its architectural register. The block tracks this with one bit per physical register, updated by rename events.

Three more events act on the valid flags:
- Dispatching a new producer into the out-of-order core invalidates that register's copy at once.
- A flush input drops every copy. This is always safe, because the file only holds duplicates.
- A recovery port repairs one register per cycle after a misspeculation. It either invalidates the entry or refills it from the main file, and it moves the newest-renaming bit from the wrong-path physical register back to the restored one.

All inputs are plain strobes with no ready signal. The file never applies back-pressure: every strobe is consumed in the cycle it is presented. Results appear on the read ports in the cycle after the edge that stores them.

Top module: `regcopy_file`

## Requirements
- R1: After reset every entry reads with valid 0 and data 0.
- R2: A write-back on any lane whose physical destination has its newest bit set stores the data in the entry named by the lane's architectural number and sets its valid flag. The result is visible on the read ports after the next rising edge.
- R3: A write-back whose physical destination has its newest bit clear changes neither the valid flag nor the data of any entry.
- R4: A rename event sets the newest bit of the new physical register and clears the bit of the one it replaces, taking effect at the same edge. When one physical register is both set and cleared in a cycle, the set wins.
- R5: A dispatch into the out-of-order core clears the valid flag of its architectural destination at the next edge, even if a write-back targets the same entry in that cycle.
- R6: The flush input clears every valid flag at the next edge and overrides every other event.
- R7: A recovery with rec_refill=1 writes rec_data and sets valid. With rec_refill=0 it clears valid. In both cases it clears the newest bit of rec_wrong_phys and sets that of rec_restore_phys. Recovery overrides write-backs to the same entry but yields to dispatch clear and flush.
- R8: The two read ports are combinational and independent. Port r returns the valid flag and data of the entry selected by rd_arch[r*5 +: 5] in the same cycle.
- R9: When several accepted write-backs name the same entry in one cycle, the data of the highest-numbered lane is stored.
- R10: After reset the newest bit is set for physical registers 0 to 31 and clear for 32 to 95, so physical register p initially maps architectural register p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename event strobe |
| ren_new_phys | input | 7 | Physical register that becomes newest |
| ren_old_phys | input | 7 | Physical register being superseded |
| disp_ooo_valid | input | 1 | A producer is dispatched to the out-of-order core |
| disp_ooo_arch | input | 5 | Architectural destination of that producer |
| wb_valid | input | 3 | Write-back strobe per lane (lane 2 is the side lane) |
| wb_phys | input | 21 | Physical destination per lane, 7 bits each |
| wb_arch | input | 15 | Architectural destination per lane, 5 bits each |
| wb_data | input | 96 | Result per lane, 32 bits each |
| flush_all | input | 1 | Drop every copy |
| rec_valid | input | 1 | Recovery action for one register |
| rec_refill | input | 1 | 1: refill with rec_data, 0: invalidate |
| rec_arch | input | 5 | Register being repaired |
| rec_restore_phys | input | 7 | Physical register that is newest again |
| rec_wrong_phys | input | 7 | Wrong-path physical register to demote |
| rec_data | input | 32 | Value from the main register file |
| rd_arch | input | 10 | Read address per port, 5 bits each |
| rd_valid | output | 2 | Valid flag per read port |
| rd_data | output | 64 | Data per read port, 32 bits each |

## Verification
The hardest case to bring about is a result that arrives for a physical register after a rename has demoted it. This is the case R3 rejects. It needs a rename and a later write-back of the superseded register, and the entry must already hold a known value so that a wrong overwrite is visible. Directed sequences build exactly that, and also a dispatch clear colliding with a copy in the same cycle. Random stimulus then confines architectural numbers to a small range so that renames, dispatch clears, recoveries and multi-lane write-backs pile onto the same few entries.

// File: rtl/regcopy_pkg.sv
`timescale 1ns/1ps
package regcopy_pkg;
  typedef enum logic {
    REC_INVALIDATE = 1'b0,
    REC_REFILL     = 1'b1
  } rec_mode_e;

  function automatic int idx_bits(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/regcopy_newest.sv
`timescale 1ns/1ps
module regcopy_newest #(
  parameter int NUM_PHYS = 96,
  parameter int NUM_ARCH = 32,
  parameter int PHYS_W   = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ren_valid,
  input  logic [PHYS_W-1:0]   ren_new_phys,
  input  logic [PHYS_W-1:0]   ren_old_phys,
  input  logic                rec_valid,
  input  logic [PHYS_W-1:0]   rec_restore_phys,
  input  logic [PHYS_W-1:0]   rec_wrong_phys,
  output logic [NUM_PHYS-1:0] newest_q
);
  logic [NUM_PHYS-1:0] boot_vec;
  logic [NUM_PHYS-1:0] set_m, clr_m;

  for (genvar p = 0; p < NUM_PHYS; p++) begin : g_boot
    assign boot_vec[p] = (p < NUM_ARCH);
  end

  always_comb begin
    set_m = '0;
    clr_m = '0;
    if (ren_valid) begin
      set_m[ren_new_phys] = 1'b1;
      clr_m[ren_old_phys] = 1'b1;
    end
    if (rec_valid) begin
      set_m[rec_restore_phys] = 1'b1;
      clr_m[rec_wrong_phys]   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) newest_q <= boot_vec;
    else        newest_q <= (newest_q & ~clr_m) | set_m;
  end

  // R4: the freshly renamed physical register is newest afterwards
  p_rename_sets_newest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ren_valid |=> newest_q[$past(ren_new_phys)]);
  // R7: recovery makes the restored mapping newest again
  p_recover_sets_newest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> newest_q[$past(rec_restore_phys)]);
endmodule

// File: rtl/regcopy_wb_filter.sv
`timescale 1ns/1ps
module regcopy_wb_filter #(
  parameter int NUM_PHYS = 96,
  parameter int WB_PORTS = 3,
  parameter int PHYS_W   = 7
) (
  input  logic [NUM_PHYS-1:0]        newest_q,
  input  logic [WB_PORTS-1:0]        wb_valid,
  input  logic [WB_PORTS*PHYS_W-1:0] wb_phys,
  output logic [WB_PORTS-1:0]        wb_accept
);
  for (genvar i = 0; i < WB_PORTS; i++) begin : g_lane
    logic [PHYS_W-1:0] ph;
    assign ph = wb_phys[i*PHYS_W +: PHYS_W];
    assign wb_accept[i] = wb_valid[i] && (32'(ph) < NUM_PHYS) && newest_q[ph];
  end
endmodule

// File: rtl/regcopy_entries.sv
`timescale 1ns/1ps
module regcopy_entries
  import regcopy_pkg::*;
#(
  parameter int NUM_ARCH = 32,
  parameter int DATA_W   = 32,
  parameter int WB_PORTS = 3,
  parameter int ARCH_W   = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        flush_all,
  input  logic                        disp_ooo_valid,
  input  logic [ARCH_W-1:0]           disp_ooo_arch,
  input  logic                        rec_valid,
  input  rec_mode_e                   rec_mode,
  input  logic [ARCH_W-1:0]           rec_arch,
  input  logic [DATA_W-1:0]           rec_data,
  input  logic [WB_PORTS-1:0]         wb_accept,
  input  logic [WB_PORTS*ARCH_W-1:0]  wb_arch,
  input  logic [WB_PORTS*DATA_W-1:0]  wb_data,
  output logic [NUM_ARCH-1:0]         valid_q,
  output logic [NUM_ARCH*DATA_W-1:0]  data_q
);
  for (genvar a = 0; a < NUM_ARCH; a++) begin : g_ent
    logic              wb_hit, disp_hit, rec_hit;
    logic [DATA_W-1:0] wb_word;

    // Highest-numbered accepted lane wins (R9)
    always_comb begin
      wb_hit  = 1'b0;
      wb_word = '0;
      for (int i = 0; i < WB_PORTS; i++) begin
        if (wb_accept[i] && wb_arch[i*ARCH_W +: ARCH_W] == ARCH_W'(a)) begin
          wb_hit  = 1'b1;
          wb_word = wb_data[i*DATA_W +: DATA_W];
        end
      end
    end

    assign disp_hit = disp_ooo_valid && (disp_ooo_arch == ARCH_W'(a));
    assign rec_hit  = rec_valid && (rec_arch == ARCH_W'(a));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[a]                    <= 1'b0;
        data_q[a*DATA_W +: DATA_W]    <= '0;
      end else if (flush_all || disp_hit) begin
        valid_q[a]                    <= 1'b0;
      end else if (rec_hit) begin
        valid_q[a] <= (rec_mode == REC_REFILL);
        if (rec_mode == REC_REFILL) data_q[a*DATA_W +: DATA_W] <= rec_data;
      end else if (wb_hit) begin
        valid_q[a]                    <= 1'b1;
        data_q[a*DATA_W +: DATA_W]    <= wb_word;
      end
    end
  end

  // R6: flush leaves no copy valid
  p_flush_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_q == '0));
  // R5: dispatch clear beats any same-cycle copy
  p_dispatch_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    disp_ooo_valid |=> !valid_q[$past(disp_ooo_arch)]);
  // R7: a refill with no clear pending leaves the entry valid with the refill data
  p_refill_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_mode == REC_REFILL && !flush_all &&
     !(disp_ooo_valid && disp_ooo_arch == rec_arch))
    |=> valid_q[$past(rec_arch)] &&
        data_q[$past(rec_arch)*DATA_W +: DATA_W] == $past(rec_data));
endmodule

// File: rtl/regcopy_read.sv
`timescale 1ns/1ps
module regcopy_read #(
  parameter int NUM_ARCH = 32,
  parameter int DATA_W   = 32,
  parameter int RD_PORTS = 2,
  parameter int ARCH_W   = 5
) (
  input  logic [NUM_ARCH-1:0]        valid_q,
  input  logic [NUM_ARCH*DATA_W-1:0] data_q,
  input  logic [RD_PORTS*ARCH_W-1:0] rd_arch,
  output logic [RD_PORTS-1:0]        rd_valid,
  output logic [RD_PORTS*DATA_W-1:0] rd_data
);
  for (genvar r = 0; r < RD_PORTS; r++) begin : g_port
    logic [ARCH_W-1:0] idx;
    logic              in_range;
    assign idx      = rd_arch[r*ARCH_W +: ARCH_W];
    assign in_range = (32'(idx) < NUM_ARCH);
    assign rd_valid[r] = in_range && valid_q[idx];
    assign rd_data[r*DATA_W +: DATA_W] = in_range ? data_q[32'(idx)*DATA_W +: DATA_W] : '0;
  end
endmodule

// File: rtl/regcopy_file.sv
`timescale 1ns/1ps
module regcopy_file
  import regcopy_pkg::*;
#(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 96,
  parameter int DATA_W   = 32,
  parameter int WB_PORTS = 3,
  parameter int RD_PORTS = 2,
  localparam int ARCH_W  = idx_bits(NUM_ARCH),
  localparam int PHYS_W  = idx_bits(NUM_PHYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ren_valid,
  input  logic [PHYS_W-1:0]           ren_new_phys,
  input  logic [PHYS_W-1:0]           ren_old_phys,
  input  logic                        disp_ooo_valid,
  input  logic [ARCH_W-1:0]           disp_ooo_arch,
  input  logic [WB_PORTS-1:0]         wb_valid,
  input  logic [WB_PORTS*PHYS_W-1:0]  wb_phys,
  input  logic [WB_PORTS*ARCH_W-1:0]  wb_arch,
  input  logic [WB_PORTS*DATA_W-1:0]  wb_data,
  input  logic                        flush_all,
  input  logic                        rec_valid,
  input  logic                        rec_refill,
  input  logic [ARCH_W-1:0]           rec_arch,
  input  logic [PHYS_W-1:0]           rec_restore_phys,
  input  logic [PHYS_W-1:0]           rec_wrong_phys,
  input  logic [DATA_W-1:0]           rec_data,
  input  logic [RD_PORTS*ARCH_W-1:0]  rd_arch,
  output logic [RD_PORTS-1:0]         rd_valid,
  output logic [RD_PORTS*DATA_W-1:0]  rd_data
);
  logic [NUM_PHYS-1:0]        newest_q;
  logic [WB_PORTS-1:0]        wb_accept;
  logic [NUM_ARCH-1:0]        valid_q;
  logic [NUM_ARCH*DATA_W-1:0] data_q;
  rec_mode_e                  rec_mode;

  assign rec_mode = rec_refill ? REC_REFILL : REC_INVALIDATE;

  regcopy_newest #(.NUM_PHYS(NUM_PHYS), .NUM_ARCH(NUM_ARCH), .PHYS_W(PHYS_W)) u_newest (
    .clk(clk), .rst_n(rst_n),
    .ren_valid(ren_valid), .ren_new_phys(ren_new_phys), .ren_old_phys(ren_old_phys),
    .rec_valid(rec_valid), .rec_restore_phys(rec_restore_phys),
    .rec_wrong_phys(rec_wrong_phys), .newest_q(newest_q));

  regcopy_wb_filter #(.NUM_PHYS(NUM_PHYS), .WB_PORTS(WB_PORTS), .PHYS_W(PHYS_W)) u_filter (
    .newest_q(newest_q), .wb_valid(wb_valid), .wb_phys(wb_phys), .wb_accept(wb_accept));

  regcopy_entries #(.NUM_ARCH(NUM_ARCH), .DATA_W(DATA_W), .WB_PORTS(WB_PORTS),
                    .ARCH_W(ARCH_W)) u_entries (
    .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
    .disp_ooo_valid(disp_ooo_valid), .disp_ooo_arch(disp_ooo_arch),
    .rec_valid(rec_valid), .rec_mode(rec_mode), .rec_arch(rec_arch), .rec_data(rec_data),
    .wb_accept(wb_accept), .wb_arch(wb_arch), .wb_data(wb_data),
    .valid_q(valid_q), .data_q(data_q));

  regcopy_read #(.NUM_ARCH(NUM_ARCH), .DATA_W(DATA_W), .RD_PORTS(RD_PORTS),
                 .ARCH_W(ARCH_W)) u_read (
    .valid_q(valid_q), .data_q(data_q), .rd_arch(rd_arch),
    .rd_valid(rd_valid), .rd_data(rd_data));

  // R3: a lone write-back on lane 0 to a superseded physical register changes nothing
  p_stale_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid == WB_PORTS'(1) && !newest_q[wb_phys[PHYS_W-1:0]] &&
     !rec_valid && !flush_all && !disp_ooo_valid)
    |=> (valid_q == $past(valid_q)) && (data_q == $past(data_q)));
endmodule

// File: tb/regcopy_file_test.sv
`timescale 1ns/1ps
module regcopy_file_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ren_valid;
  logic [6:0]  ren_new_phys, ren_old_phys;
  logic        disp_ooo_valid;
  logic [4:0]  disp_ooo_arch;
  logic [2:0]  wb_valid;
  logic [20:0] wb_phys;
  logic [14:0] wb_arch;
  logic [95:0] wb_data;
  logic        flush_all;
  logic        rec_valid, rec_refill;
  logic [4:0]  rec_arch;
  logic [6:0]  rec_restore_phys, rec_wrong_phys;
  logic [31:0] rec_data;
  logic [9:0]  rd_arch;
  logic [1:0]  rd_valid;
  logic [63:0] rd_data;

  always #4 clk = ~clk;

  regcopy_file uut (.*);

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  bit          m_valid [32];
  logic [31:0] m_data  [32];
  bit          m_newest[96];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_reads(string tag);
    for (int r = 0; r < 2; r++) begin
      int a = int'(rd_arch[r*5 +: 5]);
      chk($sformatf("%s valid port%0d arch%0d", tag, r, a), 32'(rd_valid[r]), 32'(m_valid[a]));
      chk($sformatf("%s data port%0d arch%0d", tag, r, a), rd_data[r*32 +: 32], m_data[a]);
    end
  endtask

  // Expected next state, from the requirement text
  task automatic model_commit();
    bit nv[96];
    nv = m_newest;
    if (ren_valid) nv[ren_old_phys] = 1'b0;
    if (rec_valid) nv[rec_wrong_phys] = 1'b0;
    if (ren_valid) nv[ren_new_phys] = 1'b1;
    if (rec_valid) nv[rec_restore_phys] = 1'b1;
    for (int a = 0; a < 32; a++) begin
      if (flush_all) m_valid[a] = 1'b0;
      else if (disp_ooo_valid && int'(disp_ooo_arch) == a) m_valid[a] = 1'b0;
      else if (rec_valid && int'(rec_arch) == a) begin
        m_valid[a] = rec_refill;
        if (rec_refill) m_data[a] = rec_data;
      end else begin
        for (int i = 0; i < 3; i++)
          if (wb_valid[i] && int'(wb_arch[i*5 +: 5]) == a && m_newest[wb_phys[i*7 +: 7]]) begin
            m_valid[a] = 1'b1;
            m_data[a]  = wb_data[i*32 +: 32];
          end
      end
    end
    m_newest = nv;
  endtask

  task automatic idle();
    ren_valid = 0; ren_new_phys = 0; ren_old_phys = 0;
    disp_ooo_valid = 0; disp_ooo_arch = 0;
    wb_valid = 0; wb_phys = 0; wb_arch = 0; wb_data = 0;
    flush_all = 0; rec_valid = 0; rec_refill = 0; rec_arch = 0;
    rec_restore_phys = 0; rec_wrong_phys = 0; rec_data = 0;
  endtask

  task automatic step();
    @(posedge clk);
    model_commit();
    @(negedge clk);
    idle();
  endtask

  task automatic wb(int lane, int ph, int ar, logic [31:0] d);
    wb_valid[lane] = 1'b1;
    wb_phys[lane*7 +: 7]  = 7'(ph);
    wb_arch[lane*5 +: 5]  = 5'(ar);
    wb_data[lane*32 +: 32] = d;
  endtask

  task automatic rd(int a0, int a1);
    rd_arch = {5'(a1), 5'(a0)};
    #1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    idle();
    rd_arch = 0;
    rst_n = 1'b0;
    for (int a = 0; a < 32; a++) begin m_valid[a] = 0; m_data[a] = 0; end
    for (int p = 0; p < 96; p++) m_newest[p] = (p < 32);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(0, 31);
    chk("R1 valid after reset", 32'(rd_valid), 32'd0);
    chk("R1 data after reset", rd_data[31:0], 32'd0);

    // R10 + R2: boot mapping phys 3 -> arch 3 is newest
    wb(0, 3, 3, 32'hA5A5_0003);
    step(); rd(3, 4);
    chk("R2 copy accepted valid", 32'(rd_valid[0]), 32'd1);
    chk("R10 boot newest data", rd_data[31:0], 32'hA5A5_0003);

    // R10 + R3: phys 40 is not newest after reset
    wb(1, 40, 4, 32'hDEAD_0040);
    step(); rd(4, 3);
    chk("R10 phys 40 not newest", 32'(rd_valid[0]), 32'd0);
    check_reads("R3 stale lane1");

    // R4: rename arch 4 to phys 40, then a copy from 40 lands
    ren_valid = 1; ren_new_phys = 40; ren_old_phys = 4;
    step();
    wb(2, 40, 4, 32'h0000_4040);
    step(); rd(4, 3);
    chk("R4 new phys accepted", rd_data[31:0], 32'h0000_4040);
    // R3: superseded phys 4 is ignored, value kept
    wb(0, 4, 4, 32'h1111_1111);
    step(); rd(4, 3);
    chk("R3 superseded ignored valid", 32'(rd_valid[0]), 32'd1);
    chk("R3 superseded ignored data", rd_data[31:0], 32'h0000_4040);

    // R4: set wins when one phys is both set and cleared
    ren_valid = 1; ren_new_phys = 50; ren_old_phys = 50;
    step();
    wb(0, 50, 6, 32'h0000_0050);
    step(); rd(6, 4);
    chk("R4 set wins over clear", rd_data[31:0], 32'h0000_0050);

    // R5: dispatch clear beats a same-cycle copy
    disp_ooo_valid = 1; disp_ooo_arch = 3;
    wb(0, 3, 3, 32'h3333_3333);
    step(); rd(3, 6);
    chk("R5 clear wins valid", 32'(rd_valid[0]), 32'd0);
    check_reads("R5 clear wins");

    // R9: three lanes to arch 7, highest lane's data stored
    wb(0, 7, 7, 32'h7000_0000);
    wb(1, 7, 7, 32'h7000_0001);
    wb(2, 7, 7, 32'h7000_0002);
    step(); rd(7, 6);
    chk("R9 highest lane wins", rd_data[31:0], 32'h7000_0002);

    // R7: refill arch 9 and demote wrong-path phys 40
    rec_valid = 1; rec_refill = 1; rec_arch = 9; rec_data = 32'h9999_0009;
    rec_restore_phys = 4; rec_wrong_phys = 40;
    wb(0, 9, 9, 32'h0BAD_0BAD);
    step(); rd(9, 4);
    chk("R7 refill beats copy", rd_data[31:0], 32'h9999_0009);
    chk("R7 refill valid", 32'(rd_valid[0]), 32'd1);
    wb(0, 40, 4, 32'h4444_0000);
    step(); rd(4, 9);
    chk("R7 wrong phys demoted", rd_data[31:0], 32'h0000_4040);
    wb(0, 4, 4, 32'h4444_0004);
    step(); rd(4, 9);
    chk("R7 restored phys newest", rd_data[31:0], 32'h4444_0004);
    // R7: invalidate mode
    rec_valid = 1; rec_refill = 0; rec_arch = 7; rec_restore_phys = 7; rec_wrong_phys = 60;
    step(); rd(7, 9);
    chk("R7 invalidate", 32'(rd_valid[0]), 32'd0);

    // R8: both ports independent, combinational (no clock edge between)
    rd(9, 6); check_reads("R8 pair a");
    rd(6, 9); check_reads("R8 pair b");
    rd(5, 5); check_reads("R8 pair c");

    // R6: flush overrides a copy
    flush_all = 1;
    wb(0, 9, 9, 32'hFFFF_0000);
    step();
    for (int a = 0; a < 32; a += 2) begin
      rd(a, a + 1);
      chk("R6 flush port0", 32'(rd_valid[0]), 32'd0);
      chk("R6 flush port1", 32'(rd_valid[1]), 32'd0);
    end

    // Random mix on a small range of registers
    seed = 32'd20240607;
    void'($urandom(seed));
    for (int c = 0; c < 4000; c++) begin
      if ($urandom % 100 < 30) begin
        ren_valid = 1; ren_new_phys = 7'($urandom % 96); ren_old_phys = 7'($urandom % 96);
      end
      if ($urandom % 100 < 20) begin
        disp_ooo_valid = 1; disp_ooo_arch = 5'($urandom % 8);
      end
      for (int i = 0; i < 3; i++)
        if ($urandom % 100 < 55) wb(i, int'($urandom % 96), int'($urandom % 8), $urandom);
      if ($urandom % 100 < 6) begin
        rec_valid = 1; rec_refill = 1'($urandom); rec_arch = 5'($urandom % 8);
        rec_restore_phys = 7'($urandom % 96); rec_wrong_phys = 7'($urandom % 96);
        rec_data = $urandom;
      end
      if ($urandom % 1000 < 8) flush_all = 1;
      step();
      rd(int'($urandom % 8), int'($urandom % 8));
      check_reads("R2,R3,R4,R5,R7,R9 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule